// File: doc/BRIEF.md
# Function-Coded ALU with Registered Flags

This block is the arithmetic and logic stage of a 32-bit datapath. A six-bit function code chooses the operation. An adder and a bitwise logic unit both work on the same operands, which may be inverted first. A result multiplexer then picks the output of one of the two units. The result and the four condition flags (negative, zero, carry, overflow) are captured in registers on the clock edge after the inputs are presented.

The flags change only when the caller asks for it. Arithmetic codes write all four flags. Logic and move codes write negative and zero, and load carry from a separate carry bit that the neighbouring shifter supplies. They keep the overflow flag. Any code outside the defined set yields a zero result and leaves every flag as it was.

Top module: `alu_fn_core`

## Requirements
- R1: While `rst_n` is low, `result_o` and all four flag outputs are 0.
- R2: Logic codes: 6'b000100 gives A&B, 6'b001000 gives A&~B, 6'b001001 gives A^B, and 6'b000001 gives A|B.
- R3: Move codes: 6'b000000 gives A, 6'b000101 gives B, 6'b001010 gives ~B, and 6'b001100 gives 0.
- R4: Arithmetic codes, each including `carry_i` modulo 2^32: 6'b010110 gives A+B+carry, 6'b011001 gives A+~B+carry, and 6'b110110 gives ~A+B+carry.
- R5: An arithmetic code with `upd_flags_i`=1 sets N to result bit 31 and Z to (result==0). C is set to the carry out of bit 31 of the addition. V is 1 exactly when the two adder inputs, taken after inversion, have equal bit 31 and the sum's bit 31 differs from it.
- R6: A logic or move code with `upd_flags_i`=1 sets N and Z as in R5, loads C from `shift_carry_i`, and leaves V unchanged.
- R7: With `upd_flags_i`=0 all four flags keep their values, while `result_o` still takes the new result.
- R8: Any code not listed in R2–R4 gives `result_o`=0 and leaves all four flags unchanged, whatever the value of `upd_flags_i`.
- R9: `result_o` and the flags reflect the inputs present at the previous rising clock edge, which is a latency of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand |
| carry_i | input | 1 | Carry into the adder |
| func_i | input | 6 | Function code |
| upd_flags_i | input | 1 | Request to update the flags |
| shift_carry_i | input | 1 | Shifter carry, loaded into C by logic and move codes |
| result_o | output | 32 | Registered result |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |
| flag_v_o | output | 1 | Overflow flag |

## Verification
The assertions take for granted that every input is a known value and stable at each rising edge. They also take for granted that reset is released cleanly, because the hold and overflow properties compare values one cycle apart. The bench changes inputs only on the falling edge and drives every input on every cycle. Its stimulus mixes all eleven defined codes with invalid ones, random operands and random flag-update requests. It adds directed sign-boundary operands so that carry and overflow both occur.

// File: rtl/alu_fn_pkg.sv
package alu_fn_pkg;

    localparam int FN_W = 6;

    localparam logic [FN_W-1:0] FN_PASS_A   = 6'b000000;
    localparam logic [FN_W-1:0] FN_OR       = 6'b000001;
    localparam logic [FN_W-1:0] FN_AND      = 6'b000100;
    localparam logic [FN_W-1:0] FN_PASS_B   = 6'b000101;
    localparam logic [FN_W-1:0] FN_AND_NB   = 6'b001000;
    localparam logic [FN_W-1:0] FN_XOR      = 6'b001001;
    localparam logic [FN_W-1:0] FN_NOT_B    = 6'b001010;
    localparam logic [FN_W-1:0] FN_ZERO     = 6'b001100;
    localparam logic [FN_W-1:0] FN_ADD      = 6'b010110;
    localparam logic [FN_W-1:0] FN_SUB      = 6'b011001;
    localparam logic [FN_W-1:0] FN_RSUB     = 6'b110110;

    typedef enum logic [2:0] {
        LG_AND,
        LG_OR,
        LG_XOR,
        LG_PASS_A,
        LG_PASS_B,
        LG_ZERO
    } logic_op_e;

    typedef struct packed {
        logic      valid;
        logic      arith;
        logic      inv_a;
        logic      inv_b;
        logic_op_e lop;
    } alu_ctrl_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } alu_flags_t;

endpackage

// File: rtl/alu_fn_decode.sv
module alu_fn_decode
    import alu_fn_pkg::*;
(
    input  logic [FN_W-1:0] func_i,
    output alu_ctrl_t       ctrl_o
);

    always_comb begin
        ctrl_o       = '0;
        ctrl_o.valid = 1'b1;
        ctrl_o.lop   = LG_ZERO;
        case (func_i)
            FN_AND:    ctrl_o.lop = LG_AND;
            FN_AND_NB: begin ctrl_o.lop = LG_AND;    ctrl_o.inv_b = 1'b1; end
            FN_XOR:    ctrl_o.lop = LG_XOR;
            FN_OR:     ctrl_o.lop = LG_OR;
            FN_PASS_A: ctrl_o.lop = LG_PASS_A;
            FN_PASS_B: ctrl_o.lop = LG_PASS_B;
            FN_NOT_B:  begin ctrl_o.lop = LG_PASS_B; ctrl_o.inv_b = 1'b1; end
            FN_ZERO:   ctrl_o.lop = LG_ZERO;
            FN_ADD:    ctrl_o.arith = 1'b1;
            FN_SUB:    begin ctrl_o.arith = 1'b1; ctrl_o.inv_b = 1'b1; end
            FN_RSUB:   begin ctrl_o.arith = 1'b1; ctrl_o.inv_a = 1'b1; end
            default:   ctrl_o.valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_operand_inv.sv
module alu_operand_inv #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             inv_a_i,
    input  logic             inv_b_i,
    output logic [WIDTH-1:0] a_o,
    output logic [WIDTH-1:0] b_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_xor
        assign a_o[i] = a_i[i] ^ inv_a_i;
        assign b_o[i] = b_i[i] ^ inv_b_i;
    end

endmodule

// File: rtl/alu_csel_adder.sv
module alu_csel_adder #(
    parameter int WIDTH = 32,
    parameter int BLK   = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    localparam int NBLK = WIDTH / BLK;

    logic [NBLK:0] carry;
    assign carry[0] = cin_i;

    for (genvar k = 0; k < NBLK; k++) begin : g_blk
        logic [BLK:0] s0;
        logic [BLK:0] s1;
        assign s0 = {1'b0, a_i[k*BLK +: BLK]} + {1'b0, b_i[k*BLK +: BLK]};
        assign s1 = {1'b0, a_i[k*BLK +: BLK]} + {1'b0, b_i[k*BLK +: BLK]}
                  + {{BLK{1'b0}}, 1'b1};
        assign sum_o[k*BLK +: BLK] = carry[k] ? s1[BLK-1:0] : s0[BLK-1:0];
        assign carry[k+1]          = carry[k] ? s1[BLK] : s0[BLK];
    end

    assign cout_o = carry[NBLK];

    initial begin
        assert (WIDTH % BLK == 0)
            else $error("adder width must be a multiple of the block size");
    end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_fn_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic_op_e        lop_i,
    output logic [WIDTH-1:0] res_o
);

    always_comb begin
        case (lop_i)
            LG_AND:    res_o = a_i & b_i;
            LG_OR:     res_o = a_i | b_i;
            LG_XOR:    res_o = a_i ^ b_i;
            LG_PASS_A: res_o = a_i;
            LG_PASS_B: res_o = b_i;
            default:   res_o = '0;
        endcase
    end

endmodule

// File: rtl/alu_fn_core.sv
module alu_fn_core
    import alu_fn_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int BLK   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a_i,
    input  logic [WIDTH-1:0] op_b_i,
    input  logic             carry_i,
    input  logic [FN_W-1:0]  func_i,
    input  logic             upd_flags_i,
    input  logic             shift_carry_i,
    output logic [WIDTH-1:0] result_o,
    output logic             flag_n_o,
    output logic             flag_z_o,
    output logic             flag_c_o,
    output logic             flag_v_o
);

    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] result;
        alu_flags_t       flags;
    } core_state_t;

    alu_ctrl_t        ctrl;
    logic [WIDTH-1:0] xa, xb;
    logic [WIDTH-1:0] add_sum, lg_res;
    logic             add_cout;
    logic             add_ovf;
    core_state_t      st_d, st_q;

    alu_fn_decode u_dec (
        .func_i (func_i),
        .ctrl_o (ctrl)
    );

    alu_operand_inv #(.WIDTH(WIDTH)) u_inv (
        .a_i     (op_a_i),
        .b_i     (op_b_i),
        .inv_a_i (ctrl.inv_a),
        .inv_b_i (ctrl.inv_b),
        .a_o     (xa),
        .b_o     (xb)
    );

    alu_csel_adder #(.WIDTH(WIDTH), .BLK(BLK)) u_add (
        .a_i    (xa),
        .b_i    (xb),
        .cin_i  (carry_i),
        .sum_o  (add_sum),
        .cout_o (add_cout)
    );

    alu_logic_unit #(.WIDTH(WIDTH)) u_lgc (
        .a_i   (xa),
        .b_i   (xb),
        .lop_i (ctrl.lop),
        .res_o (lg_res)
    );

    assign add_ovf = (xa[MSB] == xb[MSB]) && (add_sum[MSB] != xa[MSB]);

    always_comb begin
        st_d = st_q;
        if (!ctrl.valid) begin
            st_d.result = '0;
        end else begin
            st_d.result = ctrl.arith ? add_sum : lg_res;
            if (upd_flags_i) begin
                st_d.flags.n = st_d.result[MSB];
                st_d.flags.z = (st_d.result == '0);
                if (ctrl.arith) begin
                    st_d.flags.c = add_cout;
                    st_d.flags.v = add_ovf;
                end else begin
                    st_d.flags.c = shift_carry_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o = st_q.result;
    assign flag_n_o = st_q.flags.n;
    assign flag_z_o = st_q.flags.z;
    assign flag_c_o = st_q.flags.c;
    assign flag_v_o = st_q.flags.v;

    assert_flags_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_flags_i |=> $stable({flag_n_o, flag_z_o, flag_c_o, flag_v_o}));

    assert_bad_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.valid |=> (result_o == '0)
                        && $stable({flag_n_o, flag_z_o, flag_c_o, flag_v_o}));

    assert_logic_keeps_v_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.valid && !ctrl.arith && upd_flags_i)
            |=> $stable(flag_v_o) && (flag_c_o == $past(shift_carry_i)));

    assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.valid && upd_flags_i) |=> (flag_z_o == (result_o == '0))
                                        && (flag_n_o == result_o[MSB]));

    assert_overflow_rule_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.arith && ctrl.valid && upd_flags_i)
            |=> flag_v_o == (($past(xa[MSB]) == $past(xb[MSB]))
                             && (result_o[MSB] != $past(xa[MSB]))));

endmodule

// File: tb/alu_fn_core_bench.sv
module alu_fn_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        cin = 1'b0, upd = 1'b0, scar = 1'b0;
    logic [5:0]  func = '0;
    logic [31:0] result;
    logic        fn, fz, fc, fv;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] m_res = '0;
    logic        m_n = 0, m_z = 0, m_c = 0, m_v = 0;
    string       m_tag_r, m_tag_f;

    always #5 clk = ~clk;

    alu_fn_core u_alu_fn_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_a_i        (op_a),
        .op_b_i        (op_b),
        .carry_i       (cin),
        .func_i        (func),
        .upd_flags_i   (upd),
        .shift_carry_i (scar),
        .result_o      (result),
        .flag_n_o      (fn),
        .flag_z_o      (fz),
        .flag_c_o      (fc),
        .flag_v_o      (fv)
    );

    task automatic check(string tag, logic [35:0] act, logic [35:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference: updates model state for inputs applied this cycle.
    task automatic model();
        logic [31:0] aa, bb;
        logic [32:0] s;
        int kind; // 0 logic/move, 1 arith, 2 invalid
        kind = 0;
        aa = op_a; bb = op_b;
        case (func)
            6'b000100: begin m_res = op_a & op_b;  m_tag_r = "R2"; end
            6'b001000: begin m_res = op_a & ~op_b; m_tag_r = "R2"; end
            6'b001001: begin m_res = op_a ^ op_b;  m_tag_r = "R2"; end
            6'b000001: begin m_res = op_a | op_b;  m_tag_r = "R2"; end
            6'b000000: begin m_res = op_a;         m_tag_r = "R3"; end
            6'b000101: begin m_res = op_b;         m_tag_r = "R3"; end
            6'b001010: begin m_res = ~op_b;        m_tag_r = "R3"; end
            6'b001100: begin m_res = 32'd0;        m_tag_r = "R3"; end
            6'b010110: begin kind = 1; end
            6'b011001: begin kind = 1; bb = ~op_b; end
            6'b110110: begin kind = 1; aa = ~op_a; end
            default:   begin kind = 2; m_res = 32'd0; m_tag_r = "R8"; end
        endcase
        if (kind == 1) begin
            s = {1'b0, aa} + {1'b0, bb} + {32'd0, cin};
            m_res = s[31:0];
            m_tag_r = "R4";
        end
        if (kind == 2) m_tag_f = "R8";
        else if (!upd) m_tag_f = "R7";
        else begin
            m_n = m_res[31];
            m_z = (m_res == 32'd0);
            if (kind == 1) begin
                m_c = s[32];
                m_v = (aa[31] == bb[31]) && (m_res[31] != aa[31]);
                m_tag_f = "R5";
            end else begin
                m_c = scar;
                m_tag_f = "R6";
            end
        end
    endtask

    // Drive on the falling edge, compare on the next falling edge (R9).
    task automatic step(logic [31:0] a, logic [31:0] b, logic c,
                        logic [5:0] f, logic u, logic sc);
        op_a = a; op_b = b; cin = c; func = f; upd = u; scar = sc;
        model();
        @(negedge clk);
        check({m_tag_r, "/R9 result"}, {4'd0, result}, {4'd0, m_res});
        check({m_tag_f, "/R9 flags"}, {32'd0, fn, fz, fc, fv},
              {32'd0, m_n, m_z, m_c, m_v});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [5:0] codes [11];
        codes = '{6'b000100, 6'b001000, 6'b001001, 6'b000001, 6'b000000,
                  6'b000101, 6'b001010, 6'b001100, 6'b010110, 6'b011001,
                  6'b110110};
        // R1: reset state, with inputs active
        op_a = 32'hFFFF_FFFF; func = 6'b000000; upd = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 result", {4'd0, result}, 36'd0);
        check("R1 flags", {32'd0, fn, fz, fc, fv}, 36'd0);
        rst_n = 1'b1;
        // R2 / R3 directed
        step(32'hF0F0_1234, 32'h0FF0_FFFF, 0, 6'b000100, 1, 1);
        step(32'hF0F0_1234, 32'h0FF0_FFFF, 0, 6'b001000, 1, 0);
        step(32'hAAAA_5555, 32'hAAAA_5555, 0, 6'b001001, 1, 1);
        step(32'h8000_0000, 32'h0000_0001, 0, 6'b000001, 1, 0);
        step(32'h1234_5678, 32'h0, 0, 6'b000000, 1, 1);
        step(32'h0, 32'h8765_4321, 0, 6'b000101, 1, 0);
        step(32'h0, 32'h0, 0, 6'b001010, 1, 1);
        step(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 6'b001100, 1, 0);
        // R4 / R5 sign and carry boundaries
        step(32'h7FFF_FFFF, 32'h0000_0001, 0, 6'b010110, 1, 0);
        step(32'h8000_0000, 32'h8000_0000, 0, 6'b010110, 1, 0);
        step(32'hFFFF_FFFF, 32'h0000_0000, 1, 6'b010110, 1, 0);
        step(32'h0000_0005, 32'h0000_0005, 1, 6'b011001, 1, 0);
        step(32'h0000_0003, 32'h0000_0005, 1, 6'b011001, 1, 0);
        step(32'h8000_0000, 32'h0000_0001, 1, 6'b011001, 1, 0);
        step(32'h0000_0001, 32'h8000_0000, 1, 6'b110110, 1, 0);
        // R6: logic after an overflow keeps V
        step(32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 6'b010110, 1, 0);
        step(32'h0, 32'h0, 0, 6'b001100, 1, 1);
        // R7: no update, result still moves
        step(32'h1, 32'h1, 0, 6'b010110, 0, 1);
        step(32'hFFFF_FFFF, 32'h0, 0, 6'b000000, 0, 0);
        // R8: invalid codes with and without update
        step(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 6'b111111, 1, 1);
        step(32'h1234_5678, 32'h1, 0, 6'b000010, 0, 0);
        step(32'h1, 32'h1, 1, 6'b010111, 1, 1);
        // mixed random stimulus
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] f;
            logic [31:0] a, b;
            f = ($urandom_range(0, 7) == 0) ? 6'($urandom) : codes[$urandom_range(0, 10)];
            a = $urandom; b = $urandom;
            if ($urandom_range(0, 5) == 0) a = {1'b1, 31'd0} ^ 32'($urandom_range(0, 1));
            if ($urandom_range(0, 5) == 0) b = 32'hFFFF_FFFF;
            step(a, b, 1'($urandom), f, 1'($urandom_range(0, 3) != 0), 1'($urandom));
        end
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule